// File: doc/BRIEF.md
# Split-Word Ones-Complement Adder

This block adds or subtracts fixed-point operands in ones-complement arithmetic. A carry that leaves the top bit of an adding lane is fed back into the bottom bit of the same lane (end-around carry). Subtraction is done by adding the bitwise complement of the second operand.

There are four lane layouts. Full-word mode treats the low 36-bit word as one lane. Half mode and third mode cut that word into two 18-bit lanes or three 12-bit lanes, and each lane keeps its own end-around carry. Double mode joins the high and low words into one 72-bit lane.

The operation is launched with a one-cycle start strobe. One cycle later the result register, the carry and overflow designators and a done pulse are all updated together. The designators change only on full-word and double operations, so a sequence of split-word operations leaves them as the last wide operation set them.

Top module: `splitword_oc_adder`

## Requirements
- R1: With mode code 2'b00 (full word), the result low word is the ones-complement sum of a_lo_i and the second operand's low word, with end-around carry at bit 35. The result high word is zero, and a_hi_i and b_hi_i have no effect.
- R2: When sub_i is 1, the second operand is replaced by its bitwise complement before adding, in every mode. For example, x minus x gives all ones (negative zero).
- R3: With mode code 2'b01 (half), bits 35..18 and bits 17..0 of the low word are summed as two separate lanes. Each lane has its own end-around carry, and no carry crosses between them. The result high word is zero.
- R4: With mode code 2'b10 (third), bits 35..24, 23..12 and 11..0 are summed as three separate lanes. Each lane has its own end-around carry, and no carry crosses between them. The result high word is zero.
- R5: With mode code 2'b11 (double), {a_hi_i,a_lo_i} and the second operand's {hi,lo} are summed as one 72-bit lane with end-around carry at bit 71. The result appears on {sum_hi_o,sum_lo_o}.
- R6: After a full-word or double operation, carry_o holds the raw carry out of the lane's top bit, taken before the end-around wrap.
- R7: After a full-word or double operation, ovf_o is 1 exactly when the two addends (second one after any complement) have equal top bits and the result's top bit differs from them.
- R8: Half and third operations leave carry_o and ovf_o unchanged.
- R9: The result and designators are updated on the clock edge that samples start_i high. done_o is high for exactly that one following cycle.
- R10: While start_i is low, changes on the operand, mode and subtract inputs have no effect on sum_hi_o, sum_lo_o, carry_o or ovf_o.
- R11: Synchronous reset clears all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Launch strobe, one cycle |
| mode_i | input | 2 | 00 full, 01 half, 10 third, 11 double |
| sub_i | input | 1 | 1 = subtract (complement second operand) |
| a_hi_i | input | 36 | First operand high word (double mode only) |
| a_lo_i | input | 36 | First operand low word |
| b_hi_i | input | 36 | Second operand high word (double mode only) |
| b_lo_i | input | 36 | Second operand low word |
| sum_hi_o | output | 36 | Registered result high word |
| sum_lo_o | output | 36 | Registered result low word |
| carry_o | output | 1 | Carry designator |
| ovf_o | output | 1 | Overflow designator |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Every result is due exactly one clock edge after the start strobe is sampled. The bench drives the strobe on a falling edge and checks sums, designators and done_o on the next falling edge. On that same falling edge it drops the strobe and scrambles every other input. One cycle later it checks that done_o has fallen and that all results are still held. The expected values come from a lane-by-lane ones-complement model in the bench, which also carries its own copy of the designators across split-word operations.

// File: rtl/ocadd_pkg.sv
package ocadd_pkg;
  typedef enum logic [1:0] {
    MODE_FULL   = 2'b00,
    MODE_HALF   = 2'b01,
    MODE_THIRD  = 2'b10,
    MODE_DOUBLE = 2'b11
  } add_mode_e;
endpackage

// File: rtl/oc_lane.sv
// One ones-complement adding lane with end-around carry.
module oc_lane #(
  parameter int W = 36
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W:0] raw;

  always_comb begin
    raw  = {1'b0, a} + {1'b0, b};
    cout = raw[W];
    sum  = raw[W-1:0] + {{(W-1){1'b0}}, raw[W]};
  end
endmodule

// File: rtl/split_bank.sv
// Word cut into LANES independent ones-complement lanes.
module split_bank #(
  parameter int WORD_W = 36,
  parameter int LANES  = 2
) (
  input  logic [WORD_W-1:0] a,
  input  logic [WORD_W-1:0] b,
  output logic [WORD_W-1:0] sum,
  output logic [LANES-1:0]  cy
);
  localparam int LW = WORD_W / LANES;

  for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
    oc_lane #(.W(LW)) u_lane (
      .a    (a[gi*LW +: LW]),
      .b    (b[gi*LW +: LW]),
      .sum  (sum[gi*LW +: LW]),
      .cout (cy[gi])
    );
  end
endmodule

// File: rtl/splitword_oc_adder.sv
module splitword_oc_adder
  import ocadd_pkg::*;
#(
  parameter int WORD_W = 36
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [1:0]        mode_i,
  input  logic              sub_i,
  input  logic [WORD_W-1:0] a_hi_i,
  input  logic [WORD_W-1:0] a_lo_i,
  input  logic [WORD_W-1:0] b_hi_i,
  input  logic [WORD_W-1:0] b_lo_i,
  output logic [WORD_W-1:0] sum_hi_o,
  output logic [WORD_W-1:0] sum_lo_o,
  output logic              carry_o,
  output logic              ovf_o,
  output logic              done_o
);
  localparam int DW = 2 * WORD_W;
  localparam int HW = WORD_W / 2;
  localparam int TW = WORD_W / 3;

  add_mode_e         mode;
  logic [WORD_W-1:0] b_hi_eff, b_lo_eff;
  logic [WORD_W-1:0] full_sum, half_sum, third_sum;
  logic [DW-1:0]     dbl_sum;
  logic              full_cy, dbl_cy;
  logic [1:0]        half_cy;
  logic [2:0]        third_cy;
  logic [WORD_W-1:0] nxt_hi, nxt_lo;
  logic              nxt_c, nxt_v, upd_flags;

  assign mode     = add_mode_e'(mode_i);
  assign b_hi_eff = sub_i ? ~b_hi_i : b_hi_i;
  assign b_lo_eff = sub_i ? ~b_lo_i : b_lo_i;

  oc_lane #(.W(WORD_W)) u_full (
    .a(a_lo_i), .b(b_lo_eff), .sum(full_sum), .cout(full_cy));

  oc_lane #(.W(DW)) u_dbl (
    .a({a_hi_i, a_lo_i}), .b({b_hi_eff, b_lo_eff}),
    .sum(dbl_sum), .cout(dbl_cy));

  split_bank #(.WORD_W(WORD_W), .LANES(2)) u_half (
    .a(a_lo_i), .b(b_lo_eff), .sum(half_sum), .cy(half_cy));

  split_bank #(.WORD_W(WORD_W), .LANES(3)) u_third (
    .a(a_lo_i), .b(b_lo_eff), .sum(third_sum), .cy(third_cy));

  always_comb begin
    nxt_hi    = '0;
    nxt_lo    = full_sum;
    nxt_c     = full_cy;
    nxt_v     = (a_lo_i[WORD_W-1] == b_lo_eff[WORD_W-1]) &&
                (full_sum[WORD_W-1] != a_lo_i[WORD_W-1]);
    upd_flags = 1'b1;
    case (mode)
      MODE_HALF: begin
        nxt_lo    = half_sum;
        upd_flags = 1'b0;
      end
      MODE_THIRD: begin
        nxt_lo    = third_sum;
        upd_flags = 1'b0;
      end
      MODE_DOUBLE: begin
        nxt_hi = dbl_sum[DW-1:WORD_W];
        nxt_lo = dbl_sum[WORD_W-1:0];
        nxt_c  = dbl_cy;
        nxt_v  = (a_hi_i[WORD_W-1] == b_hi_eff[WORD_W-1]) &&
                 (dbl_sum[DW-1] != a_hi_i[WORD_W-1]);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_hi_o <= '0;
      sum_lo_o <= '0;
      carry_o  <= 1'b0;
      ovf_o    <= 1'b0;
      done_o   <= 1'b0;
    end else begin
      done_o <= start_i;
      if (start_i) begin
        sum_hi_o <= nxt_hi;
        sum_lo_o <= nxt_lo;
        if (upd_flags) begin
          carry_o <= nxt_c;
          ovf_o   <= nxt_v;
        end
      end
    end
  end

  AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (rst)
    start_i |=> done_o); // R9
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    !start_i |=> !done_o); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !start_i |=> $stable(sum_hi_o) && $stable(sum_lo_o) && $stable(carry_o) && $stable(ovf_o)); // R10
  AST_SPLIT_FLAGS: assert property (@(posedge clk) disable iff (rst)
    start_i && (mode_i == 2'b01 || mode_i == 2'b10) |=> $stable(carry_o) && $stable(ovf_o)); // R8
  AST_SINGLE_HI_ZERO: assert property (@(posedge clk) disable iff (rst)
    start_i && mode_i != 2'b11 |=> sum_hi_o == '0); // R1
  AST_HALF_WRAP: assert property (@(posedge clk) disable iff (rst)
    start_i && mode_i == 2'b01 && half_cy[0] |=> sum_lo_o[HW-1:0] != '0); // R3
  AST_THIRD_WRAP: assert property (@(posedge clk) disable iff (rst)
    start_i && mode_i == 2'b10 && third_cy[2] |=> sum_lo_o[WORD_W-1:WORD_W-TW] != '0); // R4
endmodule

// File: tb/tb_splitword_oc_adder.sv
module tb_splitword_oc_adder;
  localparam int W = 36;

  logic         clk = 1'b0;
  logic         rst;
  logic         start_i;
  logic [1:0]   mode_i;
  logic         sub_i;
  logic [W-1:0] a_hi_i, a_lo_i, b_hi_i, b_lo_i;
  logic [W-1:0] sum_hi_o, sum_lo_o;
  logic         carry_o, ovf_o, done_o;

  int nchk = 0;
  int nerr = 0;

  logic [W-1:0] e_hi, e_lo;
  logic         e_c, e_v;

  always #2 clk = ~clk;

  splitword_oc_adder #(.WORD_W(W)) dut (
    .clk(clk), .rst(rst), .start_i(start_i), .mode_i(mode_i), .sub_i(sub_i),
    .a_hi_i(a_hi_i), .a_lo_i(a_lo_i), .b_hi_i(b_hi_i), .b_lo_i(b_lo_i),
    .sum_hi_o(sum_hi_o), .sum_lo_o(sum_lo_o), .carry_o(carry_o),
    .ovf_o(ovf_o), .done_o(done_o));

  task automatic chk(input string tag, input logic [71:0] act, input logic [71:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // returns {raw carry, wrapped lane sum}
  function automatic logic [72:0] lane_add(input logic [71:0] a, input logic [71:0] b,
                                           input int w);
    logic [72:0] m, t;
    logic c;
    m = (73'd1 << w) - 73'd1;
    t = ({1'b0, a} & m) + ({1'b0, b} & m);
    c = t[w];
    t = ((t & m) + {72'd0, c}) & m;
    return {c, t[71:0]};
  endfunction

  task automatic model(input logic [1:0] md, input logic sb, input logic [W-1:0] ah,
                       input logic [W-1:0] al, input logic [W-1:0] bh, input logic [W-1:0] bl);
    logic [W-1:0] beh, bel;
    logic [72:0]  r;
    logic [71:0]  acc;
    beh = sb ? ~bh : bh;
    bel = sb ? ~bl : bl;
    e_hi = '0;
    case (md)
      2'b00: begin
        r = lane_add({36'd0, al}, {36'd0, bel}, 36);
        e_lo = r[35:0];
        e_c = r[72];
        e_v = (al[35] == bel[35]) && (r[35] != al[35]);
      end
      2'b01, 2'b10: begin
        acc = '0;
        for (int i = 0; i < ((md == 2'b01) ? 2 : 3); i++) begin
          int lw;
          lw = (md == 2'b01) ? 18 : 12;
          r = lane_add({36'd0, al} >> (lw*i), {36'd0, bel} >> (lw*i), lw);
          acc = acc | (r[71:0] << (lw*i));
        end
        e_lo = acc[35:0];
      end
      default: begin
        r = lane_add({ah, al}, {beh, bel}, 72);
        e_hi = r[71:36];
        e_lo = r[35:0];
        e_c = r[72];
        e_v = (ah[35] == beh[35]) && (r[71] != ah[35]);
      end
    endcase
  endtask

  task automatic run_op(input logic [1:0] md, input logic sb, input logic [W-1:0] ah,
                        input logic [W-1:0] al, input logic [W-1:0] bh, input logic [W-1:0] bl);
    string tag;
    @(negedge clk);
    start_i = 1'b1; mode_i = md; sub_i = sb;
    a_hi_i = ah; a_lo_i = al; b_hi_i = bh; b_lo_i = bl;
    model(md, sb, ah, al, bh, bl);
    case (md)
      2'b00: tag = "R1";
      2'b01: tag = "R3";
      2'b10: tag = "R4";
      default: tag = "R5";
    endcase
    if (sb) tag = {tag, " R2"};
    @(negedge clk);
    start_i = 1'b0;
    mode_i = 2'($urandom); sub_i = 1'($urandom);
    a_hi_i = {4'($urandom), 32'($urandom)}; a_lo_i = {4'($urandom), 32'($urandom)};
    b_hi_i = {4'($urandom), 32'($urandom)}; b_lo_i = {4'($urandom), 32'($urandom)};
    chk({tag, " sum"}, {sum_hi_o, sum_lo_o}, {e_hi, e_lo});
    chk((md == 2'b00 || md == 2'b11) ? "R6 carry" : "R8 carry", {71'd0, carry_o}, {71'd0, e_c});
    chk((md == 2'b00 || md == 2'b11) ? "R7 ovf" : "R8 ovf", {71'd0, ovf_o}, {71'd0, e_v});
    chk("R9 done high", {71'd0, done_o}, 72'd1);
    @(negedge clk);
    chk("R9 done pulse", {71'd0, done_o}, 72'd0);
    chk("R10 hold", {sum_hi_o, sum_lo_o}, {e_hi, e_lo});
    chk("R10 hold flags", {70'd0, carry_o, ovf_o}, {70'd0, e_c, e_v});
  endtask

  initial begin
    #(200000 * 4);
    nerr++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1; start_i = 1'b0; mode_i = '0; sub_i = 1'b0;
    a_hi_i = '0; a_lo_i = '0; b_hi_i = '0; b_lo_i = '0;
    e_c = 1'b0; e_v = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 reset sums", {sum_hi_o, sum_lo_o}, 72'd0);
    chk("R11 reset flags", {69'd0, carry_o, ovf_o, done_o}, 72'd0);
    rst = 1'b0;

    // directed corners
    run_op(2'b00, 1'b0, 36'h123456789, 36'd0, 36'hABCDEF012, 36'hFFFFFFFFF); // +0 + -0
    run_op(2'b00, 1'b0, '0, 36'd1, '0, 36'hFFFFFFFFF);                     // wrap -> 1
    run_op(2'b00, 1'b0, '0, 36'h7FFFFFFFF, '0, 36'd1);                     // overflow
    run_op(2'b01, 1'b0, '0, 36'h00003FFFF, '0, 36'd1);                     // low half wrap only
    run_op(2'b00, 1'b1, '0, 36'h13579BDF0, '0, 36'h13579BDF0);             // x - x
    run_op(2'b10, 1'b0, '0, 36'hFFF000FFF, '0, 36'h001000001);             // third wraps
    run_op(2'b11, 1'b0, 36'h000000000, 36'hFFFFFFFFF, 36'd0, 36'd1);       // carry across words
    run_op(2'b11, 1'b0, 36'hFFFFFFFFF, 36'hFFFFFFFFF, 36'hFFFFFFFFF, 36'hFFFFFFFFF);
    run_op(2'b10, 1'b1, '0, 36'h800800800, '0, 36'h7FF7FF7FF);
    run_op(2'b11, 1'b1, 36'h7FFFFFFFF, 36'hFFFFFFFFF, 36'h800000000, 36'd0);

    for (int n = 0; n < 300; n++) begin
      run_op(2'($urandom), 1'($urandom),
             {4'($urandom), 32'($urandom)}, {4'($urandom), 32'($urandom)},
             {4'($urandom), 32'($urandom)}, {4'($urandom), 32'($urandom)});
    end

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule